// File: doc/BRIEF.md
# Multi-Buffer SPI Slave Receiver

This block is the receive side of an SPI slave. It samples 8-bit words from the serial line and stores them in an array of eight receive slots. Each slot has its own 16-bit control word. While chip select is low, successive words go into successive slots. Each time the highest slot is written, the block raises a DMA request so that an external engine can copy the group out.

The hold bit in the control word of the highest slot decides what happens to a long frame. With the bit set, filling continues at slot 0 and produces another DMA request eight words later. With the bit clear, the group stops and every further word of that frame is dropped and counted as an overrun. A compatibility mode sends every word to slot 0, never raises a DMA request and ignores all hold bits.

A register port lets software write and read back the control words, read the received data, select the mode, and read or clear two sticky flags: overrun, and DMA error (the highest slot was written again before the previous request was acknowledged). The SPI pins are oversampled by the system clock through two-stage synchronisers. SCLK must therefore stay high and low for at least three system clocks each.

Top module: `mbrx_top`

## Requirements
- R1: With cs_n low, a word is assembled from 8 bits sampled on rising SCLK edges, MSB first, and is stored as bits 7:0 of the slot data read (reg_addr 0..7, upper bits read 0).
- R2: In buffered mode (config reg_addr 0x10 bit 0 = 1), the words of one frame fill slots 0, 1, … 7 in ascending order.
- R3: Every write to slot 7 sets dma_req. dma_req stays high until dma_ack is sampled high.
- R4: If bit 12 (hold) of the slot 7 control word is 0, words that arrive after slot 7 is filled in the same frame are dropped and leave all slots unchanged.
- R5: If the slot 7 hold bit is 1, filling wraps to slot 0 and continues. A 16-word frame therefore raises two DMA requests and the slots end up holding words 9 to 16.
- R6: The overrun flag (status reg_addr 0x11 bit 0) is set when a word is dropped. It stays set until a status write with bit 0 = 1.
- R7: The DMA error flag (status bit 1) is set when slot 7 is written while dma_req is still high and dma_ack is low. It stays set until a status write with bit 1 = 1.
- R8: In compatibility mode (config bit 0 = 0), every word is written to slot 0, hold bits have no effect, dma_req stays low and no overrun is flagged.
- R9: Raising cs_n ends the frame. The next frame starts at slot 0, a partly received word is discarded, and a stopped group is released.
- R10: After reset, all slots and control words read 0, the config reads 1 (buffered), the status reads 0, dma_req is low and miso is low (receive only).
- R11: Control words written at reg_addr 0..7 read back in full, all 16 bits, at reg_addr 8..15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| cs_n | input | 1 | Chip select, active low |
| miso | output | 1 | Serial data to the master, held low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| dma_req | output | 1 | DMA request, set on a slot 7 write |
| dma_ack | input | 1 | DMA acknowledge, clears the request |

## Verification
The bench builds the block with its defaults: eight slots, 8-bit words and 16-bit control words. With these values a 16-word frame crosses the slot 7 boundary exactly once, so a single frame exercises the stop path, the wrap path and the second DMA request. The SCLK half period is four system clocks. This keeps each bit and each frame boundary clear of the synchroniser latency, so that partial-word discard and frame restart can be checked at exact slot addresses.

// File: rtl/mbrx_pkg.sv
package mbrx_pkg;
    localparam int DEF_SLOTS  = 8;
    localparam int DEF_WORD_W = 8;
    localparam int CTRL_W     = 16;
    localparam int HOLD_BIT   = 12;

    typedef struct packed {
        logic [2:0]  bmode;
        logic        hold;
        logic [11:0] rsvd;
    } slot_ctrl_t;

    typedef enum logic [1:0] {
        RG_DATA = 2'b00,
        RG_CTRL = 2'b01,
        RG_GLOB = 2'b10,
        RG_NONE = 2'b11
    } reg_region_e;

    function automatic logic [CTRL_W-1:0] pack_ctrl(slot_ctrl_t c);
        return c;
    endfunction
endpackage

// File: rtl/mbrx_spi_front.sv
module mbrx_spi_front #(
    parameter int WORD_W = mbrx_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              cs_n,
    output logic              cs_act,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [1:0] sclk_s, mosi_s, csn_s;
    logic       sclk_q;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              rise;

    assign rise   = sclk_s[1] & ~sclk_q;
    assign cs_act = ~csn_s[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s <= '0;
            mosi_s <= '0;
            csn_s  <= '1;
            sclk_q <= 1'b0;
            shreg  <= '0;
            bitcnt <= '0;
            word_valid <= 1'b0;
            word   <= '0;
        end else begin
            sclk_s <= {sclk_s[0], sclk};
            mosi_s <= {mosi_s[0], mosi};
            csn_s  <= {csn_s[0], cs_n};
            sclk_q <= sclk_s[1];
            word_valid <= 1'b0;
            if (csn_s[1]) begin
                bitcnt <= '0;
            end else if (rise) begin
                shreg <= {shreg[WORD_W-2:0], mosi_s[1]};
                if (bitcnt == CNT_W'(WORD_W - 1)) begin
                    bitcnt     <= '0;
                    word_valid <= 1'b1;
                    word       <= {shreg[WORD_W-2:0], mosi_s[1]};
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mbrx_seq.sv
module mbrx_seq #(
    parameter int NUM_SLOTS = mbrx_pkg::DEF_SLOTS,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              word_valid,
    input  logic              buf_mode,
    input  logic              hold_last,
    input  logic              dma_ack,
    input  logic              clr_ovr,
    input  logic              clr_err,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              dma_req,
    output logic              overrun,
    output logic              dma_err
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    logic stopped, wr_last, drop;

    assign wr_en   = word_valid & cs_act & (~buf_mode | ~stopped);
    assign wr_slot = buf_mode ? cur_slot : '0;
    assign wr_last = wr_en & buf_mode & (cur_slot == LAST);
    assign drop    = word_valid & cs_act & buf_mode & stopped;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_slot <= '0;
            stopped  <= 1'b0;
            dma_req  <= 1'b0;
            overrun  <= 1'b0;
            dma_err  <= 1'b0;
        end else begin
            if (wr_last)      dma_req <= 1'b1;
            else if (dma_ack) dma_req <= 1'b0;

            if (wr_last && dma_req && !dma_ack) dma_err <= 1'b1;
            else if (clr_err)                   dma_err <= 1'b0;

            if (drop)         overrun <= 1'b1;
            else if (clr_ovr) overrun <= 1'b0;

            if (!cs_act) begin
                cur_slot <= '0;
                stopped  <= 1'b0;
            end else if (wr_en && buf_mode) begin
                if (cur_slot == LAST) begin
                    cur_slot <= '0;
                    stopped  <= ~hold_last;
                end else begin
                    cur_slot <= cur_slot + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mbrx_store.sv
module mbrx_store #(
    parameter int NUM_SLOTS = mbrx_pkg::DEF_SLOTS,
    parameter int WORD_W    = mbrx_pkg::DEF_WORD_W,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int CW       = mbrx_pkg::CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              ctrl_we,
    input  logic [SLOT_W-1:0] ctrl_slot,
    input  logic [CW-1:0]     ctrl_wdata,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [WORD_W-1:0] rd_word,
    output logic [CW-1:0]     rd_ctrl,
    output logic              hold_last
);
    import mbrx_pkg::*;

    slot_ctrl_t        ctrl_q [NUM_SLOTS];
    logic [WORD_W-1:0] data_q [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[g] <= '0;
                data_q[g] <= '0;
            end else begin
                if (ctrl_we && ctrl_slot == SLOT_W'(g)) ctrl_q[g] <= slot_ctrl_t'(ctrl_wdata);
                if (wr_en && wr_slot == SLOT_W'(g))     data_q[g] <= wr_word;
            end
        end
    end

    assign rd_word   = data_q[rd_slot];
    assign rd_ctrl   = pack_ctrl(ctrl_q[rd_slot]);
    assign hold_last = ctrl_q[NUM_SLOTS-1].hold;
endmodule

// File: rtl/mbrx_top.sv
module mbrx_top #(
    parameter int NUM_SLOTS = mbrx_pkg::DEF_SLOTS,
    parameter int WORD_W    = mbrx_pkg::DEF_WORD_W,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ADDR_W   = SLOT_W + 2,
    localparam int CW       = mbrx_pkg::CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              cs_n,
    output logic              miso,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CW-1:0]     reg_wdata,
    output logic [CW-1:0]     reg_rdata,
    input  logic              dma_ack,
    output logic              dma_req
);
    import mbrx_pkg::*;

    logic              cs_act, word_valid, wr_en, hold_last;
    logic              buf_mode, overrun, dma_err, clr_ovr, clr_err;
    logic [WORD_W-1:0] word, rd_word;
    logic [SLOT_W-1:0] wr_slot, cur_slot, sel_slot;
    logic [CW-1:0]     rd_ctrl;
    reg_region_e       region;
    logic              is_cfg, is_stat;

    assign region   = reg_region_e'(reg_addr[ADDR_W-1:SLOT_W]);
    assign sel_slot = reg_addr[SLOT_W-1:0];
    assign is_cfg   = (region == RG_GLOB) && (sel_slot == '0);
    assign is_stat  = (region == RG_GLOB) && (sel_slot == SLOT_W'(1));
    assign clr_ovr  = reg_we & is_stat & reg_wdata[0];
    assign clr_err  = reg_we & is_stat & reg_wdata[1];
    assign miso     = 1'b0;

    always_ff @(posedge clk) begin
        if (rst)                  buf_mode <= 1'b1;
        else if (reg_we && is_cfg) buf_mode <= reg_wdata[0];
    end

    always_comb begin
        reg_rdata = '0;
        case (region)
            RG_DATA: reg_rdata = CW'(rd_word);
            RG_CTRL: reg_rdata = rd_ctrl;
            RG_GLOB: begin
                if (is_cfg)  reg_rdata = CW'(buf_mode);
                if (is_stat) reg_rdata = CW'({dma_err, overrun});
            end
            default: reg_rdata = '0;
        endcase
    end

    mbrx_spi_front #(.WORD_W(WORD_W)) front_i (
        .clk(clk), .rst(rst), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .cs_act(cs_act), .word_valid(word_valid), .word(word)
    );

    mbrx_seq #(.NUM_SLOTS(NUM_SLOTS)) seq_i (
        .clk(clk), .rst(rst), .cs_act(cs_act), .word_valid(word_valid),
        .buf_mode(buf_mode), .hold_last(hold_last), .dma_ack(dma_ack),
        .clr_ovr(clr_ovr), .clr_err(clr_err), .wr_en(wr_en), .wr_slot(wr_slot),
        .cur_slot(cur_slot), .dma_req(dma_req), .overrun(overrun), .dma_err(dma_err)
    );

    mbrx_store #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W)) store_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot), .wr_word(word),
        .ctrl_we(reg_we && region == RG_DATA), .ctrl_slot(sel_slot),
        .ctrl_wdata(reg_wdata), .rd_slot(sel_slot), .rd_word(rd_word),
        .rd_ctrl(rd_ctrl), .hold_last(hold_last)
    );
endmodule

// File: rtl/mbrx_checker.sv
module mbrx_checker #(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_act,
    input logic              wr_en,
    input logic [SLOT_W-1:0] wr_slot,
    input logic [SLOT_W-1:0] cur_slot,
    input logic              buf_mode,
    input logic              dma_req,
    input logic              dma_ack,
    input logic              overrun,
    input logic              clr_ovr
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    assert_dma_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_req) |-> $past(wr_en && wr_slot == LAST && buf_mode));

    assert_dma_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !dma_ack) |=> dma_req);

    assert_frame_restart_R9: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> cur_slot == '0);

    assert_compat_slot0_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !buf_mode) |-> wr_slot == '0);

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr_ovr) |=> overrun);

    assert_no_dma_compat_R8: assert property (@(posedge clk) disable iff (rst)
        (!buf_mode && !$past(buf_mode) && !dma_req) |=> !$rose(dma_req));
endmodule

bind mbrx_top mbrx_checker #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
    .clk(clk), .rst(rst), .cs_act(cs_act), .wr_en(wr_en), .wr_slot(wr_slot),
    .cur_slot(cur_slot), .buf_mode(buf_mode), .dma_req(dma_req),
    .dma_ack(dma_ack), .overrun(overrun), .clr_ovr(clr_ovr)
);

// File: tb/mbrx_top_tb_top.sv
module mbrx_top_tb_top;
    logic clk = 1'b0, rst = 1'b1;
    logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1, miso;
    logic reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic dma_ack = 1'b0, dma_req;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mbrx_top dut_i (
        .clk(clk), .rst(rst), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dma_ack(dma_ack), .dma_req(dma_req)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            mosi = b[i]; wait_clk(4);
            sclk = 1'b1; wait_clk(4);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_on();  cs_n = 1'b0; wait_clk(4); endtask
    task automatic cs_off(); wait_clk(8); cs_n = 1'b1; wait_clk(8); endtask

    task automatic ack();
        @(negedge clk); dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        for (int s = 0; s < 8; s++) begin
            reg_rd(5'(s), d);     check(d, 16'h0, "R10 slot data");
            reg_rd(5'(8 + s), d); check(d, 16'h0, "R10 ctrl word");
        end
        reg_rd(5'h10, d); check(d, 16'h1, "R10 config");
        reg_rd(5'h11, d); check(d, 16'h0, "R10 status");
        check({15'h0, dma_req}, 16'h0, "R10 dma_req");
        check({15'h0, miso}, 16'h0, "R10 miso");
    endtask

    task automatic t_ctrl_rb();
        logic [15:0] d;
        reg_wr(5'd3, 16'hABCD);
        reg_rd(5'd11, d); check(d, 16'hABCD, "R11 ctrl readback");
        reg_wr(5'd3, 16'h0);
    endtask

    task automatic t_fill8();
        logic [15:0] d;
        reg_wr(5'd7, 16'h8000);
        cs_on();
        for (int i = 0; i < 8; i++) begin
            send_bits(8'hA0 + 8'(i), 8);
            if (i == 6) begin wait_clk(8); check({15'h0, dma_req}, 16'h0, "R3 no req before slot 7"); end
        end
        cs_off();
        for (int s = 0; s < 8; s++) begin
            reg_rd(5'(s), d); check(d, 16'h00A0 + 16'(s), "R1 R2 ascending fill");
        end
        check({15'h0, dma_req}, 16'h1, "R3 req set");
        wait_clk(10);
        check({15'h0, dma_req}, 16'h1, "R3 req held");
        ack(); #1;
        check({15'h0, dma_req}, 16'h0, "R3 req cleared by ack");
    endtask

    task automatic t_stop();
        logic [15:0] d;
        reg_wr(5'd7, 16'h8000);
        cs_on();
        for (int i = 0; i < 16; i++) send_bits(8'h10 + 8'(i), 8);
        cs_off();
        for (int s = 0; s < 8; s++) begin
            reg_rd(5'(s), d); check(d, 16'h0010 + 16'(s), "R4 excess dropped");
        end
        reg_rd(5'h11, d); check(d, 16'h1, "R6 overrun set, R4 one request");
        ack();
        wait_clk(5);
        reg_rd(5'h11, d); check(d, 16'h1, "R6 overrun sticky");
        reg_wr(5'h11, 16'h1);
        reg_rd(5'h11, d); check(d, 16'h0, "R6 overrun cleared");
        cs_on(); send_bits(8'h77, 8); cs_off();
        reg_rd(5'd0, d); check(d, 16'h0077, "R9 restart at slot 0 after stop");
        reg_rd(5'd1, d); check(d, 16'h0011, "R9 slot 1 untouched");
    endtask

    task automatic t_wrap();
        logic [15:0] d;
        reg_wr(5'd7, 16'h9000);
        cs_on();
        for (int i = 0; i < 8; i++) send_bits(8'h30 + 8'(i), 8);
        wait_clk(8);
        check({15'h0, dma_req}, 16'h1, "R5 first request");
        ack();
        #1 check({15'h0, dma_req}, 16'h0, "R5 first request acked");
        for (int i = 8; i < 16; i++) send_bits(8'h30 + 8'(i), 8);
        cs_off();
        check({15'h0, dma_req}, 16'h1, "R5 second request");
        for (int s = 0; s < 8; s++) begin
            reg_rd(5'(s), d); check(d, 16'h0038 + 16'(s), "R5 wrapped data");
        end
        reg_rd(5'h11, d); check(d, 16'h0, "R5 R7 no overrun no error");
        ack();
        cs_on();
        for (int i = 0; i < 16; i++) send_bits(8'h50 + 8'(i), 8);
        cs_off();
        reg_rd(5'h11, d); check(d, 16'h2, "R7 dma error set");
        ack();
        reg_wr(5'h11, 16'h2);
        reg_rd(5'h11, d); check(d, 16'h0, "R7 dma error cleared");
    endtask

    task automatic t_partial();
        logic [15:0] d;
        cs_on(); send_bits(8'hFF, 3); cs_off();
        cs_on(); send_bits(8'h5A, 8); cs_off();
        reg_rd(5'd0, d); check(d, 16'h005A, "R9 partial word discarded");
        reg_rd(5'd1, d); check(d, 16'h0059, "R9 no spill to slot 1");
    endtask

    task automatic t_compat();
        logic [15:0] d, s1;
        reg_rd(5'd1, s1);
        reg_wr(5'h10, 16'h0);
        reg_rd(5'h10, d); check(d, 16'h0, "R8 config compat");
        reg_wr(5'd7, 16'h8000);
        cs_on();
        for (int i = 0; i < 10; i++) send_bits(8'hC0 + 8'(i), 8);
        cs_off();
        reg_rd(5'd0, d); check(d, 16'h00C9, "R8 last word in slot 0");
        reg_rd(5'd1, d); check(d, s1, "R8 slot 1 untouched");
        check({15'h0, dma_req}, 16'h0, "R8 no dma request");
        reg_rd(5'h11, d); check(d, 16'h0, "R8 no overrun with hold 0");
        reg_wr(5'd7, 16'h9000);
        cs_on();
        for (int i = 0; i < 9; i++) send_bits(8'hE0 + 8'(i), 8);
        cs_off();
        reg_rd(5'd0, d); check(d, 16'h00E8, "R8 hold 1 ignored");
        reg_rd(5'd1, d); check(d, s1, "R8 hold 1 no wrap effect");
        check({15'h0, dma_req}, 16'h0, "R8 no dma request hold 1");
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_ctrl_rb();
        t_fill8();
        t_stop();
        t_wrap();
        t_partial();
        t_compat();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule